// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is the serial front end of a small register-mapped peripheral. It runs from a system clock that is much faster than the bus and oversamples the two bus lines. Both lines pass through a synchronizer and a majority filter before any edge is detected. The block recognises start, repeated start and stop conditions. It answers one fixed 7-bit address and returns acknowledge by pulling SDA low.

In a write transfer, the first byte after the address is kept as a register pointer. Every data byte after it is handed to an external register file through a one-cycle write strobe. In a read transfer, the byte at the pointed register is taken through a one-cycle read strobe and shifted out MSB first. The pointer never advances by itself, so every byte of a transfer, and every later transfer, reaches the same register until a new pointer byte is written.

A typical read is done in two parts. The controller first writes the pointer byte. It then issues a repeated start with the read bit set and clocks in as many bytes as it needs. It ends the read with a not-acknowledge and a stop.

Top module: `i2c_ptr_target`

## Requirements
- R1: After reset, `sda_pull` is 0, both strobes are 0 and `reg_addr` is 0.
- R2: An address byte whose upper seven bits equal 7'b1000001 is acknowledged by holding `sda_pull` high through the ninth clock. The byte's bit 0 selects the direction: 0 is write and 1 is read.
- R3: An address byte with any other upper seven bits is not acknowledged. The block then drives nothing and issues no strobe until the next start or stop.
- R4: In a write transfer, the first byte after the address is acknowledged and stored as the 8-bit pointer. It issues no write strobe.
- R5: Every later byte of the same write transfer is acknowledged. When its last bit has been taken, it produces exactly one `reg_wr_en` pulse, with the byte on `reg_wdata` and the low pointer bits on `reg_addr`.
- R6: The pointer does not auto-increment. Consecutive data bytes, and consecutive read bytes, all use the same `reg_addr`.
- R7: After an acknowledged read address, the block gives one `reg_rd_en` pulse and then sends `reg_rdata` MSB first. It captures `reg_rdata` in the cycle of that pulse.
- R8: An acknowledge from the controller on a read byte makes the block fetch and send another byte from the same register. A not-acknowledge makes it release SDA and send nothing more until a start.
- R9: A pointer value of 4 or more is still acknowledged and stored. Data bytes written to it give no write strobe. Bytes read from it are 8'hFF and give no read strobe.
- R10: A start condition in the middle of any byte abandons that byte without effect and restarts address reception.
- R11: A stop condition at any bit position returns the block to idle with no strobe for the unfinished byte. The stored pointer is kept for later transfers.
- R12: A pulse on SCL or SDA lasting at most (FILT_WIN-1)/2 system clocks is ignored. It changes no bit value and causes no start or stop.
- R13: A pointer write followed by a repeated start and an address with the read bit set returns the register selected by that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls SDA low (acknowledge or a 0 data bit) |
| reg_addr | output | IDX_W | Low bits of the stored pointer |
| reg_wr_en | output | 1 | One-cycle write strobe to the register file |
| reg_wdata | output | 8 | Byte written with `reg_wr_en` |
| reg_rd_en | output | 1 | One-cycle read strobe; `reg_rdata` is captured in this cycle |
| reg_rdata | input | 8 | Register file output for `reg_addr` |

## Verification
The bench exercises the write path with several byte sequences: a single data byte, several data bytes under one pointer, and data sent to an out-of-range pointer. These show whether strobes follow the pointer and whether the pointer stays fixed. Reads with controller acknowledges, a final not-acknowledge and extra clocks after it show apart a target that keeps sending from one that stops. Start and stop conditions placed mid-address and mid-data, a foreign address, and single-clock spikes on both lines separate correct aborts and filtering from stray bit shifts and false conditions.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   localparam int BYTE_W = 8;
   localparam int BCNT_W = $clog2(BYTE_W + 1);

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_CMD,
      ST_CMD_ACK,
      ST_WDAT,
      ST_WDAT_ACK,
      ST_RDAT,
      ST_RDAT_ACK
   } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_glitch_filter.sv
module i2c_tgt_glitch_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int WIN         = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);

   localparam int CNT_W = $clog2(WIN + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], d_in};
   end

   generate
      if (WIN == 1) begin : g_pass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= 1'b1;
            else        out_q <= sync_q[SYNC_STAGES-1];
         end
      end else begin : g_major
         logic [WIN-1:0]   win_q;
         logic [CNT_W-1:0] ones;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) win_q <= '1;
            else        win_q <= {win_q[WIN-2:0], sync_q[SYNC_STAGES-1]};
         end

         always_comb begin
            ones = '0;
            for (int i = 0; i < WIN; i++) ones = ones + CNT_W'(win_q[i]);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= 1'b1;
            else        out_q <= (ones > CNT_W'(WIN / 2));
         end
      end
   endgenerate

   assign d_out = out_q;

endmodule

// File: rtl/i2c_tgt_bus_events.sv
module i2c_tgt_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_f;
         sda_p <= sda_f;
      end
   end

   assign scl_rise  =  scl_f & ~scl_p;
   assign scl_fall  = ~scl_f &  scl_p;
   assign start_det =  scl_f &  scl_p &  sda_p & ~sda_f;
   assign stop_det  =  scl_f &  scl_p & ~sda_p &  sda_f;

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
#(
   parameter logic [6:0] TGT_ADDR = 7'b1000001,
   parameter int         NUM_REGS = 4,
   parameter int         IDX_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_bit,
   output logic              sda_pull,
   output logic [BYTE_W-1:0] ptr,
   output logic [IDX_W-1:0]  reg_addr,
   output logic              reg_wr_en,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              reg_rd_en,
   input  logic [BYTE_W-1:0] reg_rdata
);

   localparam logic [BCNT_W-1:0] FULL = BCNT_W'(BYTE_W);
   localparam logic [BCNT_W-1:0] LAST = BCNT_W'(BYTE_W - 1);

   tgt_state_e          state_q;
   logic [BYTE_W-1:0]   shift_q, ptr_q, wdata_q;
   logic [BCNT_W-1:0]   bitcnt_q;
   logic                rw_q, pull_q, wr_q, rd_q, mack_q;
   logic                ptr_valid;
   logic [BYTE_W-1:0]   rd_byte;

   assign ptr_valid = ({1'b0, ptr_q} < (BYTE_W+1)'(NUM_REGS));
   assign rd_byte   = ptr_valid ? reg_rdata : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         shift_q  <= '0;
         ptr_q    <= '0;
         wdata_q  <= '0;
         bitcnt_q <= '0;
         rw_q     <= 1'b0;
         pull_q   <= 1'b0;
         wr_q     <= 1'b0;
         rd_q     <= 1'b0;
         mack_q   <= 1'b0;
      end else begin
         wr_q <= 1'b0;
         rd_q <= 1'b0;
         if (start_det) begin
            state_q  <= ST_ADDR;
            bitcnt_q <= '0;
            pull_q   <= 1'b0;
         end else if (stop_det) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            pull_q   <= 1'b0;
         end else begin
            case (state_q)
               ST_ADDR, ST_CMD, ST_WDAT: begin
                  if (scl_rise && bitcnt_q != FULL) begin
                     shift_q  <= {shift_q[BYTE_W-2:0], sda_bit};
                     bitcnt_q <= bitcnt_q + 1'b1;
                  end else if (scl_fall && bitcnt_q == FULL) begin
                     bitcnt_q <= '0;
                     if (state_q == ST_ADDR) begin
                        if (shift_q[BYTE_W-1:1] == TGT_ADDR) begin
                           rw_q    <= shift_q[0];
                           pull_q  <= 1'b1;
                           state_q <= ST_ADDR_ACK;
                        end else begin
                           state_q <= ST_IDLE;
                        end
                     end else if (state_q == ST_CMD) begin
                        ptr_q   <= shift_q;
                        pull_q  <= 1'b1;
                        state_q <= ST_CMD_ACK;
                     end else begin
                        wr_q    <= ptr_valid;
                        wdata_q <= shift_q;
                        pull_q  <= 1'b1;
                        state_q <= ST_WDAT_ACK;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     bitcnt_q <= '0;
                     if (rw_q) begin
                        shift_q <= rd_byte;
                        pull_q  <= ~rd_byte[BYTE_W-1];
                        rd_q    <= ptr_valid;
                        state_q <= ST_RDAT;
                     end else begin
                        pull_q  <= 1'b0;
                        state_q <= ST_CMD;
                     end
                  end
               end
               ST_CMD_ACK, ST_WDAT_ACK: begin
                  if (scl_fall) begin
                     bitcnt_q <= '0;
                     pull_q   <= 1'b0;
                     state_q  <= ST_WDAT;
                  end
               end
               ST_RDAT: begin
                  if (scl_fall) begin
                     if (bitcnt_q == LAST) begin
                        bitcnt_q <= '0;
                        pull_q   <= 1'b0;
                        state_q  <= ST_RDAT_ACK;
                     end else begin
                        bitcnt_q <= bitcnt_q + 1'b1;
                        shift_q  <= {shift_q[BYTE_W-2:0], 1'b0};
                        pull_q   <= ~shift_q[BYTE_W-2];
                     end
                  end
               end
               ST_RDAT_ACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_bit;
                  end else if (scl_fall) begin
                     if (mack_q) begin
                        shift_q <= rd_byte;
                        pull_q  <= ~rd_byte[BYTE_W-1];
                        rd_q    <= ptr_valid;
                        state_q <= ST_RDAT;
                     end else begin
                        pull_q  <= 1'b0;
                        state_q <= ST_IDLE;
                     end
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign sda_pull  = pull_q;
   assign ptr       = ptr_q;
   assign reg_addr  = ptr_q[IDX_W-1:0];
   assign reg_wr_en = wr_q;
   assign reg_wdata = wdata_q;
   assign reg_rd_en = rd_q;

endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target #(
   parameter logic [6:0] TGT_ADDR    = 7'b1000001,
   parameter int         NUM_REGS    = 4,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_WIN    = 3,
   localparam int        IDX_W       = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_in,
   input  logic             sda_in,
   output logic             sda_pull,
   output logic [IDX_W-1:0] reg_addr,
   output logic             reg_wr_en,
   output logic [7:0]       reg_wdata,
   output logic             reg_rd_en,
   input  logic [7:0]       reg_rdata
);

   initial begin
      if (NUM_REGS < 2 || NUM_REGS > 256) $fatal(1, "NUM_REGS must lie in 2..256");
      if (SYNC_STAGES < 2)                $fatal(1, "SYNC_STAGES must be at least 2");
      if (FILT_WIN < 1 || FILT_WIN % 2 == 0) $fatal(1, "FILT_WIN must be odd and positive");
   end

   logic [1:0] raw_w, filt_w;
   logic       scl_filt, sda_filt;
   logic       scl_rise, scl_fall, start_det, stop_det;
   logic [7:0] ptr_w;

   assign raw_w    = {sda_in, scl_in};
   assign scl_filt = filt_w[0];
   assign sda_filt = filt_w[1];

   for (genvar g = 0; g < 2; g++) begin : g_line
      i2c_tgt_glitch_filter #(
         .SYNC_STAGES(SYNC_STAGES),
         .WIN        (FILT_WIN)
      ) u_filt (
         .clk  (clk),
         .rst_n(rst_n),
         .d_in (raw_w[g]),
         .d_out(filt_w[g])
      );
   end

   i2c_tgt_bus_events u_events (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_f    (scl_filt),
      .sda_f    (sda_filt),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   i2c_tgt_engine #(
      .TGT_ADDR(TGT_ADDR),
      .NUM_REGS(NUM_REGS),
      .IDX_W   (IDX_W)
   ) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det),
      .sda_bit  (sda_filt),
      .sda_pull (sda_pull),
      .ptr      (ptr_w),
      .reg_addr (reg_addr),
      .reg_wr_en(reg_wr_en),
      .reg_wdata(reg_wdata),
      .reg_rd_en(reg_rd_en),
      .reg_rdata(reg_rdata)
   );

endmodule

// File: rtl/i2c_ptr_target_chk.sv
module i2c_ptr_target_chk #(
   parameter int NUM_REGS = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_f,
   input logic       sda_pull,
   input logic       reg_wr_en,
   input logic       reg_rd_en,
   input logic [7:0] ptr
);

   // R5: a write strobe lasts a single cycle
   p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> !reg_wr_en);

   // R7: a read strobe lasts a single cycle
   p_rd_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_en |=> !reg_rd_en);

   // R9: no write strobe while the pointer is out of range
   p_wr_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> ({1'b0, ptr} < 9'(NUM_REGS)));

   // R9: no read strobe while the pointer is out of range
   p_rd_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_en |-> ({1'b0, ptr} < 9'(NUM_REGS)));

   // R2: SDA is only newly pulled while the filtered clock is low
   p_pull_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> !scl_f);

   // R6: the pointer holds still across a write strobe
   p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> $stable(ptr));

   // R4: the pointer only changes while the filtered clock is low
   p_ptr_on_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ptr) |-> !scl_f);

endmodule

bind i2c_ptr_target i2c_ptr_target_chk #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_f    (scl_filt),
   .sda_pull (sda_pull),
   .reg_wr_en(reg_wr_en),
   .reg_rd_en(reg_rd_en),
   .ptr      (ptr_w)
);

// File: tb/i2c_ptr_target_bench.sv
`timescale 1ns/1ps
module i2c_ptr_target_bench;

   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_line;
   logic       sda_pull;
   logic [1:0] reg_addr;
   logic       reg_wr_en, reg_rd_en;
   logic [7:0] reg_wdata, reg_rdata;

   logic [7:0]  rf [4];
   logic [7:0]  mreg [4];
   logic [15:0] exp_wr [$];
   int          n_checks = 0;
   int          n_fail = 0;
   int          rd_seen = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   assign sda_line  = sda_m & ~sda_pull;
   assign reg_rdata = rf[reg_addr];

   i2c_ptr_target u_i2c_ptr_target (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_in   (scl_m),
      .sda_in   (sda_line),
      .sda_pull (sda_pull),
      .reg_addr (reg_addr),
      .reg_wr_en(reg_wr_en),
      .reg_wdata(reg_wdata),
      .reg_rd_en(reg_rd_en),
      .reg_rdata(reg_rdata)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // register file behind the port; index 0 is a read-only input value
   initial begin
      rf[0] = 8'hA5; rf[1] = 8'hFF; rf[2] = 8'h00; rf[3] = 8'hFF;
      mreg[0] = 8'hA5; mreg[1] = 8'hFF; mreg[2] = 8'h00; mreg[3] = 8'hFF;
   end

   always @(posedge clk)
      if (reg_wr_en && reg_addr != 2'd0) rf[reg_addr] <= reg_wdata;

   // per-clock comparison of strobes against the expected write stream
   always @(negedge clk) begin
      if (rst_n && reg_wr_en) begin
         if (exp_wr.size() == 0) begin
            chk("R5 unexpected write strobe", {6'd0, reg_addr, reg_wdata}, 16'hFFFF);
         end else begin
            chk("R5 R6 write addr/data", {6'd0, reg_addr, reg_wdata}, exp_wr.pop_front());
         end
      end
      if (rst_n && reg_rd_en) rd_seen++;
   end

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start;
      if (!scl_m) begin
         sda_m = 1'b1; waitn(Q);
         scl_m = 1'b1; waitn(Q);
      end
      sda_m = 1'b0; waitn(Q);
      scl_m = 1'b0; waitn(Q);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; waitn(Q);
      scl_m = 1'b1; waitn(Q);
      sda_m = 1'b1; waitn(Q);
   endtask

   task automatic bit_xfer(input logic b, input bit glitch, output logic seen);
      sda_m = b;    waitn(Q);
      scl_m = 1'b1; waitn(Q);
      seen = sda_line;
      if (glitch) begin
         waitn(3);
         scl_m = 1'b0; waitn(1);
         scl_m = 1'b1; waitn(3);
         if (b) begin sda_m = 1'b0; waitn(1); sda_m = 1'b1; end
      end
      waitn(Q);
      scl_m = 1'b0; waitn(Q);
   endtask

   task automatic wr_byte(input logic [7:0] v, input bit glitch, output bit acked);
      logic s;
      for (int i = 7; i >= 0; i--) bit_xfer(v[i], glitch, s);
      bit_xfer(1'b1, 1'b0, s);
      acked = (s == 1'b0);
   endtask

   task automatic part_bits(input logic [7:0] v, input int n);
      logic s;
      for (int i = 0; i < n; i++) bit_xfer(v[7-i], 1'b0, s);
   endtask

   task automatic rd_byte(input bit ack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bit_xfer(1'b1, 1'b0, s);
         d[i] = s;
      end
      bit_xfer(~ack, 1'b0, s);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      bit         a;
      logic [7:0] d;

      waitn(5);
      // R1: reset state
      chk("R1 sda_pull", {15'd0, sda_pull}, 16'd0);
      chk("R1 strobes", {14'd0, reg_wr_en, reg_rd_en}, 16'd0);
      chk("R1 reg_addr", {14'd0, reg_addr}, 16'd0);
      rst_n = 1'b1;
      waitn(10);

      // R2 R4 R5: single write to register 3
      bus_start();
      wr_byte(8'h82, 0, a); chk("R2 address ack", {15'd0, a}, 16'd1);
      wr_byte(8'h03, 0, a); chk("R4 pointer ack", {15'd0, a}, 16'd1);
      chk("R4 no strobe for pointer", 16'(exp_wr.size()), 16'd0);
      exp_wr.push_back({8'd3, 8'hF0}); mreg[3] = 8'hF0;
      wr_byte(8'hF0, 0, a); chk("R5 data ack", {15'd0, a}, 16'd1);
      bus_stop();
      chk("R5 write delivered", 16'(exp_wr.size()), 16'd0);

      // R13 R7 R8 R6: pointer write, repeated start, three reads
      rd_seen = 0;
      bus_start();
      wr_byte(8'h82, 0, a);
      wr_byte(8'h03, 0, a);
      bus_start();
      wr_byte(8'h83, 0, a); chk("R2 read address ack", {15'd0, a}, 16'd1);
      rd_byte(1, d); chk("R13 R7 first read byte", {8'd0, d}, {8'd0, mreg[3]});
      rd_byte(1, d); chk("R8 R6 second read byte", {8'd0, d}, {8'd0, mreg[3]});
      rd_byte(0, d); chk("R8 R6 last read byte", {8'd0, d}, {8'd0, mreg[3]});
      rd_byte(0, d); chk("R8 released after nack", {8'd0, d}, 16'h00FF);
      bus_stop();
      chk("R7 read strobe count", 16'(rd_seen), 16'd3);

      // R6: two data bytes under one pointer reach the same register
      bus_start();
      wr_byte(8'h82, 0, a);
      wr_byte(8'h01, 0, a);
      exp_wr.push_back({8'd1, 8'h3C});
      exp_wr.push_back({8'd1, 8'h5A}); mreg[1] = 8'h5A;
      wr_byte(8'h3C, 0, a);
      wr_byte(8'h5A, 0, a); chk("R6 second data ack", {15'd0, a}, 16'd1);
      bus_stop();
      chk("R6 both writes delivered", 16'(exp_wr.size()), 16'd0);

      // R13: read the input register
      bus_start();
      wr_byte(8'h82, 0, a);
      wr_byte(8'h00, 0, a);
      bus_start();
      wr_byte(8'h83, 0, a);
      rd_byte(0, d); chk("R13 input register read", {8'd0, d}, {8'd0, mreg[0]});
      bus_stop();

      // R10: start in the middle of a data byte and of an address byte
      bus_start();
      wr_byte(8'h82, 0, a);
      wr_byte(8'h02, 0, a);
      part_bits(8'hC3, 4);
      bus_start();
      part_bits(8'h82, 3);
      bus_start();
      wr_byte(8'h83, 0, a); chk("R10 address after abort ack", {15'd0, a}, 16'd1);
      rd_byte(0, d); chk("R10 aborted data not written", {8'd0, d}, {8'd0, mreg[2]});
      bus_stop();
      chk("R10 no write strobe", 16'(exp_wr.size()), 16'd0);

      // R3: foreign addresses
      rd_seen = 0;
      bus_start();
      wr_byte(8'h80, 0, a); chk("R3 foreign write address nack", {15'd0, a}, 16'd0);
      wr_byte(8'h00, 0, a); chk("R3 silent after mismatch", {15'd0, a}, 16'd0);
      bus_stop();
      bus_start();
      wr_byte(8'h87, 0, a); chk("R3 foreign read address nack", {15'd0, a}, 16'd0);
      rd_byte(0, d); chk("R3 no data driven", {8'd0, d}, 16'h00FF);
      bus_stop();
      chk("R3 no read strobe", 16'(rd_seen), 16'd0);

      // R9 R11: out-of-range pointer kept across stop
      bus_start();
      wr_byte(8'h82, 0, a);
      wr_byte(8'h07, 0, a); chk("R9 large pointer ack", {15'd0, a}, 16'd1);
      wr_byte(8'h99, 0, a); chk("R9 data ack", {15'd0, a}, 16'd1);
      bus_stop();
      chk("R9 no write strobe", 16'(exp_wr.size()), 16'd0);
      rd_seen = 0;
      bus_start();
      wr_byte(8'h83, 0, a);
      rd_byte(1, d); chk("R9 R11 read gives FF", {8'd0, d}, 16'h00FF);
      rd_byte(0, d); chk("R9 second read gives FF", {8'd0, d}, 16'h00FF);
      bus_stop();
      chk("R9 no read strobe", 16'(rd_seen), 16'd0);

      // R11: stop inside a data byte, pointer kept afterwards
      bus_start();
      wr_byte(8'h82, 0, a);
      wr_byte(8'h03, 0, a);
      part_bits(8'h00, 3);
      bus_stop();
      chk("R11 no write after stop", 16'(exp_wr.size()), 16'd0);
      rd_seen = 0;
      bus_start();
      wr_byte(8'h83, 0, a);
      rd_byte(0, d); chk("R11 pointer kept", {8'd0, d}, {8'd0, mreg[3]});
      bus_stop();
      chk("R11 one read strobe", 16'(rd_seen), 16'd1);

      // R12: one-clock spikes on both lines during a data byte
      bus_start();
      wr_byte(8'h82, 0, a);
      wr_byte(8'h03, 0, a);
      exp_wr.push_back({8'd3, 8'h6B}); mreg[3] = 8'h6B;
      wr_byte(8'h6B, 1, a); chk("R12 ack despite spikes", {15'd0, a}, 16'd1);
      bus_stop();
      chk("R12 write delivered", 16'(exp_wr.size()), 16'd0);
      bus_start();
      wr_byte(8'h83, 0, a);
      rd_byte(0, d); chk("R12 value read back", {8'd0, d}, {8'd0, mreg[3]});
      bus_stop();

      waitn(20);
      finish_run();
   end

endmodule